// File: doc/BRIEF.md
# Cache Lookup and Miss Classifier

This block is the front of a small set-associative data cache. Each cycle it accepts at most one CPU load or store. The request carries an address and a flag that says whether the access may be cached. The block compares the address tag against every way of the indexed set. Each way keeps four status bits: present, readable, writable and modified.

Every accepted request is given one of seven result codes. Those results are then the input to the miss queue, the write buffer and the CPU response path. The block also keeps the status bits up to date. It does this on write hits, on line fills (shared or exclusive), on write-permission grants and on invalidations. When a fill replaces a modified line, it emits a writeback address. A registered blocked output tells the CPU side that requests are being refused.

Lower-level traffic enters through one update port. An update has priority over a request in the same cycle. Line data, the lower-level protocol and any replacement scheme beyond one rotating pointer per set are outside this block.

Top module: `cache_lookup_classifier`

## Requirements
- R1: After reset every way is not present, `blocked`, `rsp_valid` and `wb_valid` are low, and every rotating pointer names way 0.
- R2: A cacheable read whose tag matches a present and readable way gets result code 0 (read hit).
- R3: A cacheable write whose tag matches a present, readable and writable way gets code 1 (write hit) and sets that way's modified bit.
- R4: A cacheable write whose tag matches a present, readable way that lacks write permission gets code 2 (upgrade, no data needed).
- R5: A cacheable read with no usable match gets code 3 (line fill). A cacheable write with no matching present way gets code 4 (exclusive line fill).
- R6: An uncacheable request gets code 5. If its tag matches a present way, that way is cleared (all four bits low), so a later cacheable access to it misses.
- R7: `blocked` equals the OR of `mshr_full` and `wbuf_full` sampled one cycle earlier. A request arriving while `blocked` is high, or in the same cycle as `upd_valid`, gets code 6 (rejected) and changes no state.
- R8: Update op 0 fills a line as present and readable. Op 1 fills it as present, readable and writable. Op 2 sets writable on a matching present, readable way. Op 3 clears a matching way. A fill whose tag is already present rewrites that way.
- R9: A fill with no matching way uses the lowest-numbered way that is not present. If every way is present, it uses the set's rotating pointer, which then advances by one, wrapping at the way count.
- R10: When a fill replaces a present and modified line, `wb_valid` pulses high one cycle later with `wb_addr` = {old tag, set index, zero offset}.
- R11: A request sampled at clock edge k shows `rsp_valid` and `rsp_class` after edge k+HIT_LAT-1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_cacheable | input | 1 | 1 = cacheable region |
| req_addr | input | ADDR_W | Request byte address |
| upd_valid | input | 1 | Status update from the lower level |
| upd_op | input | 2 | 0 fill shared, 1 fill exclusive, 2 grant write, 3 invalidate |
| upd_addr | input | ADDR_W | Line address of the update |
| mshr_full | input | 1 | Miss queue has no free entry |
| wbuf_full | input | 1 | Write buffer has no free entry |
| blocked | output | 1 | Requests are being refused |
| rsp_valid | output | 1 | Result available |
| rsp_class | output | 3 | Result code (0..6) |
| wb_valid | output | 1 | Modified line evicted |
| wb_addr | output | ADDR_W | Line address to write back |

## Verification
A wrong status bit in a way stays hidden until the next request or fill for that set. It then appears as a wrong result code HIT_LAT cycles after that request, or as a missing or spurious writeback one cycle after the fill. A rotating pointer that advances wrongly shows up only at the next full-set fill, as the wrong line address on `wb_addr`. The reference model therefore runs the same random traffic over a few sets and tags. This keeps sets full, so every latent error is exposed within a few cycles.

// File: rtl/clc_pkg.sv
package clc_pkg;
  typedef enum logic [2:0] {
    CLS_RD_HIT   = 3'd0,
    CLS_WR_HIT   = 3'd1,
    CLS_UPGRADE  = 3'd2,
    CLS_RD_MISS  = 3'd3,
    CLS_RDX_MISS = 3'd4,
    CLS_UNCACHED = 3'd5,
    CLS_REJECT   = 3'd6
  } cls_e;

  typedef enum logic [1:0] {
    UPD_FILL_SH = 2'd0,
    UPD_FILL_EX = 2'd1,
    UPD_GRANT   = 2'd2,
    UPD_INVAL   = 2'd3
  } upd_e;

  typedef struct packed {
    logic v;
    logic r;
    logic w;
    logic d;
  } line_flags_t;
endpackage

// File: rtl/clc_tag_store.sv
module clc_tag_store
  import clc_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 10,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [WAYS-1:0][TAG_W-1:0]    rd_tag,
  output line_flags_t [WAYS-1:0]        rd_flags,
  input  logic [WAYS-1:0]               wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [TAG_W-1:0]              wr_tag,
  input  line_flags_t                   wr_flags
);
  logic [TAG_W-1:0] tag_mem  [SETS][WAYS];
  line_flags_t      flag_mem [SETS][WAYS];

  // tags carry no reset so they can map onto RAM
  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++)
      if (wr_en[w]) tag_mem[wr_idx][w] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          flag_mem[s][w] <= '0;
    end else begin
      for (int w = 0; w < WAYS; w++)
        if (wr_en[w]) flag_mem[wr_idx][w] <= wr_flags;
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_tag[w]   = tag_mem[rd_idx][w];
      rd_flags[w] = flag_mem[rd_idx][w];
    end
  end
endmodule

// File: rtl/clc_victim.sv
module clc_victim #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic [WAYS-1:0]  present,
  input  logic             advance,
  output logic [WAY_W-1:0] victim,
  output logic             from_rr
);
  logic [WAY_W-1:0] rr_q [SETS];

  always_comb begin
    victim  = rr_q[idx];
    from_rr = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!present[w]) begin
        victim  = WAY_W'(w);
        from_rr = 1'b0;
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (advance) begin
      rr_q[idx] <= (rr_q[idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[idx] + 1'b1;
    end
  end
endmodule

// File: rtl/clc_rsp_pipe.sv
module clc_rsp_pipe #(
  parameter int DEPTH = 2,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic         v_q [DEPTH];
  logic [W-1:0] d_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) v_q[g] <= 1'b0;
      else     v_q[g] <= (g == 0) ? in_valid : v_q[(g == 0) ? 0 : g - 1];
      d_q[g] <= (g == 0) ? in_data : d_q[(g == 0) ? 0 : g - 1];
    end
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_data  = d_q[DEPTH-1];
endmodule

// File: rtl/cache_lookup_classifier.sv
module cache_lookup_classifier
  import clc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFFS_W  = 4,
  parameter int SETS    = 4,
  parameter int WAYS    = 2,
  parameter int HIT_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_cacheable,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              upd_valid,
  input  logic [1:0]        upd_op,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              mshr_full,
  input  logic              wbuf_full,
  output logic              blocked,
  output logic              rsp_valid,
  output logic [2:0]        rsp_class,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - IDX_W - OFFS_W;

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  line_flags_t [WAYS-1:0] rd_flags;
  logic [WAYS-1:0] present, match, wr_en;
  line_flags_t wr_flags, hit_f;
  logic [WAY_W-1:0] hit_way, victim, fill_way;
  logic any_match, from_rr, rr_adv, evict, cls_v, blocked_q, wb_valid_q;
  logic [ADDR_W-1:0] evict_addr, wb_addr_q;
  cls_e cls;

  assign lk_idx = upd_valid ? upd_addr[OFFS_W +: IDX_W] : req_addr[OFFS_W +: IDX_W];
  assign lk_tag = upd_valid ? upd_addr[ADDR_W-1 -: TAG_W] : req_addr[ADDR_W-1 -: TAG_W];

  clc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst), .rd_idx(lk_idx), .rd_tag(rd_tag), .rd_flags(rd_flags),
    .wr_en(wr_en), .wr_idx(lk_idx), .wr_tag(lk_tag), .wr_flags(wr_flags)
  );

  clc_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk(clk), .rst(rst), .idx(lk_idx), .present(present), .advance(rr_adv),
    .victim(victim), .from_rr(from_rr)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      present[w] = rd_flags[w].v;
      match[w]   = rd_flags[w].v && (rd_tag[w] == lk_tag);
      if (match[w]) hit_way = WAY_W'(w);
    end
    any_match = |match;
    hit_f     = rd_flags[hit_way];
    fill_way  = any_match ? hit_way : victim;
  end

  always_comb begin
    wr_en      = '0;
    wr_flags   = '0;
    rr_adv     = 1'b0;
    evict      = 1'b0;
    evict_addr = {rd_tag[victim], lk_idx, {OFFS_W{1'b0}}};
    cls_v      = req_valid;
    cls        = CLS_REJECT;
    if (upd_valid) begin
      case (upd_e'(upd_op))
        UPD_FILL_SH, UPD_FILL_EX: begin
          wr_en[fill_way] = 1'b1;
          wr_flags = '{v: 1'b1, r: 1'b1, w: (upd_op == UPD_FILL_EX), d: 1'b0};
          if (!any_match) begin
            evict  = rd_flags[victim].v && rd_flags[victim].d;
            rr_adv = from_rr;
          end
        end
        UPD_GRANT: if (any_match && hit_f.r) begin
          wr_en[hit_way] = 1'b1;
          wr_flags       = hit_f;
          wr_flags.w     = 1'b1;
        end
        default: if (any_match) wr_en[hit_way] = 1'b1;
      endcase
    end else if (req_valid && !blocked_q) begin
      if (!req_cacheable) begin
        cls = CLS_UNCACHED;
        if (any_match) wr_en[hit_way] = 1'b1;
      end else if (!req_write) begin
        cls = (any_match && hit_f.r) ? CLS_RD_HIT : CLS_RD_MISS;
      end else if (any_match && hit_f.r && hit_f.w) begin
        cls            = CLS_WR_HIT;
        wr_en[hit_way] = 1'b1;
        wr_flags       = hit_f;
        wr_flags.d     = 1'b1;
      end else if (any_match && hit_f.r) begin
        cls = CLS_UPGRADE;
      end else begin
        cls = CLS_RDX_MISS;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blocked_q  <= 1'b0;
      wb_valid_q <= 1'b0;
    end else begin
      blocked_q  <= mshr_full | wbuf_full;
      wb_valid_q <= evict;
    end
    wb_addr_q <= evict_addr;
  end

  clc_rsp_pipe #(.DEPTH(HIT_LAT), .W(3)) u_pipe (
    .clk(clk), .rst(rst), .in_valid(cls_v), .in_data(cls),
    .out_valid(rsp_valid), .out_data(rsp_class)
  );

  assign blocked  = blocked_q;
  assign wb_valid = wb_valid_q;
  assign wb_addr  = wb_addr_q;
endmodule

// File: rtl/clc_checker.sv
module clc_checker #(
  parameter int WAYS  = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst,
  input logic             mshr_full,
  input logic             wbuf_full,
  input logic             blocked,
  input logic             upd_valid,
  input logic [1:0]       upd_op,
  input logic             wb_valid,
  input logic [WAYS-1:0]  present,
  input logic [WAY_W-1:0] victim,
  input logic             from_rr
);
  // R7
  blocked_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (blocked == $past(mshr_full | wbuf_full)));

  // R10
  wb_after_update_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(upd_valid));

  // R10
  wb_fill_only_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> ($past(upd_op) <= 2'd1));

  // R9
  victim_free_way_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&present)) |-> (!present[victim] && !from_rr));
endmodule

bind cache_lookup_classifier clc_checker #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst(rst), .mshr_full(mshr_full), .wbuf_full(wbuf_full),
  .blocked(blocked), .upd_valid(upd_valid), .upd_op(upd_op), .wb_valid(wb_valid),
  .present(present), .victim(victim), .from_rr(from_rr)
);

// File: tb/tb_cache_lookup_classifier.sv
module tb_cache_lookup_classifier;
  localparam int ADDR_W = 16, OFFS_W = 4, SETS = 4, WAYS = 2, HIT_LAT = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_cacheable = 0, upd_valid = 0;
  logic mshr_full = 0, wbuf_full = 0;
  logic [1:0] upd_op = 0;
  logic [ADDR_W-1:0] req_addr = 0, upd_addr = 0;
  logic blocked, rsp_valid, wb_valid;
  logic [2:0] rsp_class;
  logic [ADDR_W-1:0] wb_addr;

  int total = 0, bad = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  cache_lookup_classifier #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .SETS(SETS),
    .WAYS(WAYS), .HIT_LAT(HIT_LAT)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_cacheable(req_cacheable), .req_addr(req_addr), .upd_valid(upd_valid),
    .upd_op(upd_op), .upd_addr(upd_addr), .mshr_full(mshr_full),
    .wbuf_full(wbuf_full), .blocked(blocked), .rsp_valid(rsp_valid),
    .rsp_class(rsp_class), .wb_valid(wb_valid), .wb_addr(wb_addr));

  function automatic logic [15:0] mk(int t, int s, int o);
    return {t[9:0], s[1:0], o[3:0]};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  int mtag [SETS][WAYS];
  bit mv [SETS][WAYS], mr [SETS][WAYS], mw [SETS][WAYS], md [SETS][WAYS];
  int mrr [SETS];
  bit pv [HIT_LAT];
  int pc [HIT_LAT];
  bit m_blk, m_wbv;
  int m_wba;
  int s_i, t_i, hw, vw, ncls;
  bit nv;

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        mrr[s] = 0;
        for (int w = 0; w < WAYS; w++) begin
          mv[s][w] = 0; mr[s][w] = 0; mw[s][w] = 0; md[s][w] = 0; mtag[s][w] = 0;
        end
      end
      for (int i = 0; i < HIT_LAT; i++) begin pv[i] = 0; pc[i] = 0; end
      m_blk = 0; m_wbv = 0; m_wba = 0;
    end else begin
      nv = 0; ncls = 0; m_wbv = 0;
      if (upd_valid) begin
        s_i = upd_addr[5:4]; t_i = upd_addr[15:6]; hw = -1;
        for (int w = 0; w < WAYS; w++) if (mv[s_i][w] && mtag[s_i][w] == t_i) hw = w;
        if (upd_op <= 1) begin
          if (hw < 0) begin
            vw = -1;
            for (int w = WAYS - 1; w >= 0; w--) if (!mv[s_i][w]) vw = w;
            if (vw < 0) begin vw = mrr[s_i]; mrr[s_i] = (mrr[s_i] + 1) % WAYS; end
            if (mv[s_i][vw] && md[s_i][vw]) begin
              m_wbv = 1; m_wba = mk(mtag[s_i][vw], s_i, 0);
            end
            hw = vw;
          end
          mtag[s_i][hw] = t_i; mv[s_i][hw] = 1; mr[s_i][hw] = 1;
          mw[s_i][hw] = (upd_op == 1); md[s_i][hw] = 0;
        end else if (upd_op == 2) begin
          if (hw >= 0 && mr[s_i][hw]) mw[s_i][hw] = 1;
        end else if (hw >= 0) begin
          mv[s_i][hw] = 0; mr[s_i][hw] = 0; mw[s_i][hw] = 0; md[s_i][hw] = 0;
        end
      end
      if (req_valid) begin
        nv = 1;
        s_i = req_addr[5:4]; t_i = req_addr[15:6]; hw = -1;
        for (int w = 0; w < WAYS; w++) if (mv[s_i][w] && mtag[s_i][w] == t_i) hw = w;
        if (m_blk || upd_valid) ncls = 6;
        else if (!req_cacheable) begin
          ncls = 5;
          if (hw >= 0) begin
            mv[s_i][hw] = 0; mr[s_i][hw] = 0; mw[s_i][hw] = 0; md[s_i][hw] = 0;
          end
        end else if (!req_write) ncls = (hw >= 0 && mr[s_i][hw]) ? 0 : 3;
        else if (hw >= 0 && mr[s_i][hw] && mw[s_i][hw]) begin
          ncls = 1; md[s_i][hw] = 1;
        end else if (hw >= 0 && mr[s_i][hw]) ncls = 2;
        else ncls = 4;
      end
      for (int i = HIT_LAT - 1; i > 0; i--) begin pv[i] = pv[i-1]; pc[i] = pc[i-1]; end
      pv[0] = nv; pc[0] = ncls;
      m_blk = mshr_full | wbuf_full;
    end
  end

  function automatic string cls_tag(int c);
    case (c)
      0: return "R2 R8";
      1: return "R3 R8";
      2: return "R4 R8";
      3, 4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      check(rsp_valid == pv[HIT_LAT-1], "R11 rsp_valid", rsp_valid, pv[HIT_LAT-1]);
      if (pv[HIT_LAT-1])
        check(rsp_class == pc[HIT_LAT-1], cls_tag(pc[HIT_LAT-1]), rsp_class, pc[HIT_LAT-1]);
      check(blocked == m_blk, "R7 blocked", blocked, m_blk);
      check(wb_valid == m_wbv, "R10 wb_valid", wb_valid, m_wbv);
      if (m_wbv) check(wb_addr == m_wba[15:0], "R9 R10 wb_addr", wb_addr, m_wba);
    end
  end

  task automatic cyc(bit rv, bit rw, bit rc, logic [15:0] ra,
                     bit uv, logic [1:0] uo, logic [15:0] ua, bit mf);
    req_valid = rv; req_write = rw; req_cacheable = rc; req_addr = ra;
    upd_valid = uv; upd_op = uo; upd_addr = ua; mshr_full = mf; wbuf_full = 0;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic req_expect(bit rw, bit rc, logic [15:0] ra, int exp, string req);
    cyc(1, rw, rc, ra, 0, 0, 0, 0);
    if (HIT_LAT > 1) check(rsp_valid == 0, "R11 early", rsp_valid, 0);
    for (int i = 0; i < HIT_LAT - 1; i++) idle();
    check(rsp_valid == 1, "R11 late", rsp_valid, 1);
    check(rsp_class == exp, req, rsp_class, exp);
  endtask

  task automatic upd(logic [1:0] op, logic [15:0] ua);
    cyc(0, 0, 0, 0, 1, op, ua, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(rsp_valid == 0 && wb_valid == 0 && blocked == 0, "R1 reset", rsp_valid + wb_valid + blocked, 0);
    rst = 0;
    cmp_on = 1;
    req_expect(0, 1, mk(5, 1, 3), 3, "R5 read miss");
    upd(1, mk(5, 1, 0));
    req_expect(1, 1, mk(5, 1, 8), 1, "R3 R8 write hit after exclusive fill");
    upd(0, mk(6, 1, 0));
    req_expect(1, 1, mk(6, 1, 0), 2, "R4 upgrade");
    req_expect(0, 1, mk(6, 1, 4), 0, "R2 read hit");
    upd(2, mk(6, 1, 0));
    req_expect(1, 1, mk(6, 1, 0), 1, "R8 write hit after grant");
    upd(0, mk(7, 1, 0));
    check(wb_valid == 1 && wb_addr == mk(5, 1, 0), "R9 R10 evict way0", wb_addr, mk(5, 1, 0));
    upd(0, mk(5, 1, 0));
    check(wb_valid == 1 && wb_addr == mk(6, 1, 0), "R9 rr advance", wb_addr, mk(6, 1, 0));
    req_expect(0, 0, mk(7, 1, 0), 5, "R6 uncached");
    req_expect(0, 1, mk(7, 1, 0), 3, "R6 line invalidated");
    req_expect(1, 1, mk(7, 1, 0), 4, "R5 write miss");
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    check(blocked == 1, "R7 blocked set", blocked, 1);
    req_expect(0, 1, mk(5, 1, 0), 6, "R7 reject when blocked");
    cyc(1, 0, 1, mk(5, 1, 0), 1, 3, mk(9, 2, 0), 0);
    for (int i = 0; i < HIT_LAT - 1; i++) idle();
    check(rsp_class == 6, "R7 reject with update", rsp_class, 6);
    req_expect(0, 1, mk(5, 1, 0), 0, "R7 no state change");
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      cyc(r < 70, $urandom % 2, ($urandom % 8) != 0,
          mk(1 + $urandom % 3, $urandom % 2, $urandom % 16),
          r >= 55, $urandom % 4, mk(1 + $urandom % 3, $urandom % 2, 0),
          ($urandom % 12) == 0);
    end
    repeat (HIT_LAT + 2) idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule